// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog built around a down-counter, programmed through a simple word-addressed register port. Once software turns it on, the counter falls by one on every clock. The first time it reaches zero, the block raises a pending timeout interrupt and reloads the counter from the load register. Software services the watchdog by writing the clear register. That write drops the pending flag and reloads the counter.

If the counter reaches zero again while the interrupt is still pending, the outcome depends on the reset-enable control bit. With that bit set, the block issues a one-cycle system reset request and then freezes the counter at zero. With that bit clear, it only reloads and keeps the interrupt pending. The enable bit can be set by software but never cleared; only the block reset clears it.

A lock register guards the load, control and mask registers against stray writes. Writing the key 0x1ACCE551 unlocks it. Any other value written there locks it. The interrupt-clear register stays writable while locked so that servicing is never blocked.

Top module: `wdog_top`

## Requirements
- R1: After reset the load register and counter read 0xFFFFFFFF, the control (addr 2), mask (addr 4), status (addr 5) and lock (addr 6) registers read 0, and irq_o and rst_req_o are low.
- R2: While the enable bit is 0 the counter (addr 1) holds its value. While it is 1 the counter decreases by one each clock.
- R3: On the clock where an enabled, running counter is at zero with no interrupt pending, the pending flag is set and the counter is reloaded from the load register (addr 0).
- R4: irq_o equals pending AND NOT mask, where mask is bit 0 of addr 4. Status (addr 5) bit 0 gives the raw pending flag and bit 1 gives the masked one.
- R5: Consider a zero reached while pending is set and reset-enable (bit 1 of addr 2) is 1. rst_req_o is high for exactly one cycle, and the counter then stays at zero until the block reset.
- R6: A zero reached while pending is set and reset-enable is 0 reloads the counter, leaves pending set and gives no reset request.
- R7: Any write to addr 3 clears pending and reloads the counter from the load register. When it falls in the same clock as a zero, the clear wins and no timeout or reset occurs.
- R8: A permitted write to addr 0 sets both the load register and the counter to the written value at once. It never clears pending, and it takes priority over a zero in the same clock.
- R9: Writing bit 0 of addr 2 as 1 sets the enable bit. Writing it as 0 leaves the bit unchanged.
- R10: Writing 0x1ACCE551 to addr 6 unlocks, and any other value locks; addr 6 reads 1 when locked and 0 otherwise. While locked, writes to addrs 0, 2 and 4 change nothing, but writes to addr 3 still clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Timeout interrupt, after masking |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The counter's zero event can fall in the same clock as a software write to the clear register or to the load register. The bench provokes both collisions by reading the count every cycle and issuing the write on the cycle it reads zero. A behavioural model then judges the result on every clock: the write must win, so no timeout is taken and, while pending with reset enabled, no reset request is issued. The same scheme also drives the second-zero path with and without reset-enable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD   = 3'd0,
    A_COUNT  = 3'd1,
    A_CTRL   = 3'd2,
    A_CLEAR  = 3'd3,
    A_MASK   = 3'd4,
    A_STATUS = 3'd5,
    A_LOCK   = 3'd6
  } wdog_addr_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     cnt_i,
  input  logic              pend_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     load_o,
  output logic              load_wr_o,
  output logic              clr_o,
  output logic              en_o,
  output logic              rst_en_o,
  output logic              mask_o
);
  logic [DW-1:0] load_q;
  logic en_q, rst_en_q, mask_q, locked_q;
  logic wr_load, wr_ctrl, wr_mask, wr_lock;

  assign wr_load = we_i && addr_i == A_LOAD && !locked_q;
  assign wr_ctrl = we_i && addr_i == A_CTRL && !locked_q;
  assign wr_mask = we_i && addr_i == A_MASK && !locked_q;
  assign wr_lock = we_i && addr_i == A_LOCK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= '1;
      en_q     <= 1'b0;
      rst_en_q <= 1'b0;
      mask_q   <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata_i;
      if (wr_ctrl) begin
        en_q     <= en_q | wdata_i[0];  // enable is set-only
        rst_en_q <= wdata_i[1];
      end
      if (wr_mask) mask_q <= wdata_i[0];
      if (wr_lock) locked_q <= (wdata_i != DW'(UNLOCK_KEY));
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_LOAD:   rdata_o = load_q;
      A_COUNT:  rdata_o = cnt_i;
      A_CTRL:   rdata_o[1:0] = {rst_en_q, en_q};
      A_MASK:   rdata_o[0] = mask_q;
      A_STATUS: rdata_o[1:0] = {pend_i & ~mask_q, pend_i};
      A_LOCK:   rdata_o[0] = locked_q;
      default:  rdata_o = '0;
    endcase
  end

  assign load_o    = load_q;
  assign load_wr_o = wr_load;
  assign clr_o     = we_i && addr_i == A_CLEAR;
  assign en_o      = en_q;
  assign rst_en_o  = rst_en_q;
  assign mask_o    = mask_q;

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q); // R9
  AST_LOCK_GUARDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && we_i && addr_i == A_LOAD) |=> $stable(load_q)); // R10
  AST_LOCK_GUARDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && we_i && addr_i == A_MASK) |=> $stable(mask_q)); // R10
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          rst_en_i,
  input  logic [DW-1:0] load_i,
  input  logic          load_wr_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          clr_i,
  output logic [DW-1:0] cnt_o,
  output logic          pend_o,
  output logic          rst_req_o
);
  logic [DW-1:0] cnt_q;
  logic pend_q, halt_q, rst_q;
  logic at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      pend_q <= 1'b0;
      halt_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (clr_i) pend_q <= 1'b0;
      if (!halt_q) begin
        if (load_wr_i) begin
          cnt_q <= load_data_i;
        end else if (clr_i) begin
          cnt_q <= load_i;
        end else if (en_i) begin
          if (!at_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!pend_q) begin
            pend_q <= 1'b1;
            cnt_q  <= load_i;
          end else if (rst_en_i) begin
            rst_q  <= 1'b1;
            halt_q <= 1'b1;  // frozen at zero until block reset
          end else begin
            cnt_q <= load_i;
          end
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign pend_o    = pend_q;
  assign rst_req_o = rst_q;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q); // R5
  AST_RST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> ($past(pend_q) && $past(rst_en_i))); // R5
  AST_HALT_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> at_zero); // R5
  AST_LOAD_KEEPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && load_wr_i) |=> pend_q); // R8
  AST_CLEAR_DROPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_o); // R7
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [DW-1:0] cnt, load;
  logic pend, load_wr, clr, en, rst_en, mask;

  wdog_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .pend_i(pend), .rdata_o,
    .load_o(load), .load_wr_o(load_wr), .clr_o(clr),
    .en_o(en), .rst_en_o(rst_en), .mask_o(mask)
  );

  wdog_counter #(.DW(DW)) u_cnt (
    .clk_i, .rst_ni, .en_i(en), .rst_en_i(rst_en),
    .load_i(load), .load_wr_i(load_wr), .load_data_i(wdata_i),
    .clr_i(clr), .cnt_o(cnt), .pend_o(pend), .rst_req_o
  );

  assign irq_o = pend & ~mask;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en); // R3
endmodule

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
  import wdog_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wdata = '0, rdata;
  logic irq, rst_req;
  int checks = 0, fails = 0, rst_pulses = 0;
  string cur = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  wdog_top u_dut (.clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
                  .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req));

  // behavioural reference model
  logic [31:0] m_load, m_cnt;
  bit m_en, m_ren, m_mask, m_lock, m_pend, m_halt, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_load = '1; m_cnt = '1; m_en = 0; m_ren = 0; m_mask = 0;
      m_lock = 0; m_pend = 0; m_halt = 0; m_rst = 0;
    end else begin
      bit do_load, do_clr;
      m_rst = 0;
      do_load = we && addr == 3'd0 && !m_lock;
      do_clr  = we && addr == 3'd3;
      if (do_clr) m_pend = 0;
      if (!m_halt) begin
        if (do_load) m_cnt = wdata;
        else if (do_clr) m_cnt = m_load;
        else if (m_en) begin
          if (m_cnt != 0) m_cnt = m_cnt - 1;
          else if (!m_pend) begin m_pend = 1; m_cnt = m_load; end
          else if (m_ren) begin m_rst = 1; m_halt = 1; end
          else m_cnt = m_load;
        end
      end
      if (do_load) m_load = wdata;
      if (we && addr == 3'd2 && !m_lock) begin
        if (wdata[0]) m_en = 1;
        m_ren = wdata[1];
      end
      if (we && addr == 3'd4 && !m_lock) m_mask = wdata[0];
      if (we && addr == 3'd6) m_lock = (wdata != 32'h1ACCE551);
    end
  end

  function automatic logic [31:0] m_rdata(logic [2:0] a);
    case (a)
      3'd0: return m_load;
      3'd1: return m_cnt;
      3'd2: return {30'd0, m_ren, m_en};
      3'd4: return {31'd0, m_mask};
      3'd5: return {30'd0, m_pend & ~m_mask, m_pend};
      3'd6: return {31'd0, m_lock};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    if (rst_req) rst_pulses++;
    chk(cur, {31'd0, irq}, {31'd0, m_pend & ~m_mask}, "irq_o");
    chk(cur, {31'd0, rst_req}, {31'd0, m_rst}, "rst_req_o");
    chk(cur, rdata, m_rdata(addr), $sformatf("rdata addr %0d", addr));
  endtask

  task automatic cyc(bit w, logic [2:0] a, logic [31:0] d);
    we = w; addr = a; wdata = d;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n, logic [2:0] a);
    for (int i = 0; i < n; i++) cyc(0, a, 0);
  endtask

  task automatic wait_zero_then(bit w, logic [2:0] a, logic [31:0] d);
    for (int i = 0; i < 5000; i++) begin
      cyc(0, 3'd1, 0);
      if (rdata == 0) break;
    end
    cyc(w, a, d);  // write lands on the zero cycle
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          fails++; checks++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
          $finish;
        end
      end
    join_none

    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cur = "R1";
    for (int a = 0; a < 7; a++) cyc(0, 3'(a), 0);
    chk("R1", {31'd0, irq}, 32'd0, "irq after reset");

    cur = "R2";
    cyc(1, 3'd0, 32'd10);
    idle(4, 3'd1);
    chk("R2", rdata, 32'd10, "count held while disabled");
    cur = "R9";
    cyc(1, 3'd2, 32'd1);
    cur = "R2";
    idle(3, 3'd1);
    chk("R2", rdata, 32'd7, "count after 3 enabled clocks");

    cur = "R3";
    idle(9, 3'd5);
    chk("R3", {31'd0, irq}, 32'd1, "irq after first zero");

    cur = "R4";
    cyc(1, 3'd4, 32'd1);
    cyc(0, 3'd5, 0);
    chk("R4", {31'd0, irq}, 32'd0, "irq masked");
    cyc(1, 3'd4, 32'd0);
    idle(2, 3'd5);

    cur = "R6";
    idle(14, 3'd1);
    chk("R6", {31'd0, rst_req}, 32'd0, "no reset without reset-enable");

    cur = "R7";
    cyc(1, 3'd3, 32'h0);
    chk("R7", {31'd0, irq}, 32'd0, "irq after clear");
    wait_zero_then(1, 3'd3, 32'h5);  // clear on zero with nothing pending
    idle(12, 3'd5);                  // first timeout occurs
    wait_zero_then(1, 3'd3, 32'h0);  // clear collides with second zero
    chk("R7", {31'd0, irq}, 32'd0, "clear wins over zero");

    cur = "R8";
    idle(12, 3'd5);                  // pending again
    cyc(1, 3'd0, 32'd6);
    chk("R8", {31'd0, irq}, 32'd1, "load keeps pending");
    wait_zero_then(1, 3'd0, 32'd8);  // load collides with zero
    idle(3, 3'd1);

    cur = "R9";
    cyc(1, 3'd2, 32'd0);
    cyc(0, 3'd2, 0);
    chk("R9", rdata, 32'd1, "enable survives write of 0");
    cyc(1, 3'd3, 0);

    cur = "R10";
    cyc(1, 3'd6, 32'h0);
    cyc(0, 3'd6, 0);
    chk("R10", rdata, 32'd1, "locked");
    cyc(1, 3'd0, 32'd3);
    cyc(1, 3'd4, 32'd1);
    cyc(1, 3'd2, 32'd3);
    cyc(0, 3'd0, 0);
    chk("R10", rdata, 32'd8, "load unchanged while locked");
    idle(12, 3'd5);                  // pending
    cyc(1, 3'd3, 0);
    chk("R10", {31'd0, irq}, 32'd0, "clear works while locked");
    cyc(1, 3'd6, 32'h1ACCE551);
    cyc(0, 3'd6, 0);
    chk("R10", rdata, 32'd0, "unlocked by key");

    cur = "R5";
    rst_pulses = 0;
    cyc(1, 3'd2, 32'd3);
    cyc(1, 3'd0, 32'd4);
    idle(20, 3'd1);
    chk("R5", rst_pulses, 32'd1, "single reset pulse");
    chk("R5", rdata, 32'd0, "counter frozen at zero");
    cyc(1, 3'd0, 32'd9);
    idle(3, 3'd1);
    chk("R5", rdata, 32'd0, "still frozen after load");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule